// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker for Storage DMA

This block drives one storage DMA command across a table of region descriptors held in host memory. A controller first arms the walker once the device has set up a DMA command. Arming gives the byte budget for the whole command and the direction of transfer. A start strobe then gives the table address. For each table entry the walker reads one 64-bit descriptor over a request/response memory port and checks it against the bytes that remain in the command. It waits out the modelled media latency, then hands the region to a downstream chunking engine. That engine splits the region into bus bursts and reports completion with one pulse.

When the memory port refuses a descriptor read, the walker does not poll it on every cycle. It drops the request for a fixed number of cycles and then retries. The command ends with a done pulse when the entry flagged as last finishes with the budget used up exactly. Any inconsistency ends it with an error pulse instead, as does an abort or a start strobe at the wrong time. Bus addresses pass through unchanged: translation is identity.

Top module: `prd_walker`

## Requirements
- R1: After reset no memory or transfer request is raised and neither done_o nor err_o is asserted.
- R2: start_i is accepted only in the armed state, which a pulse on arm_i enters from idle. A start_i in any other state produces an err_o pulse and returns the walker to idle, with no further descriptor fetch and no transfer.
- R3: A descriptor is one 64-bit little-endian word. The region address is in bits 31:0, the byte count in bits 47:32, reserved bits 62:48 must be zero, and bit 63 marks the last entry. The first fetch uses tbl_base_i with bits 2:0 cleared, and each later fetch uses an address 8 above the previous one.
- R4: A descriptor request presented while mrd_busy_i is high is refused. mrd_req_o then stays low for exactly BACKOFF_CYC cycles before the request is presented again.
- R5: xfer_req_o rises exactly DISK_DLY + count/512 cycles after the clock edge at which the descriptor response (mrd_vld_i) is taken.
- R6: A transfer request carries the descriptor address, the byte count, and the direction (xfer_dir_o = 1 means device to memory). The request and its fields stay stable while xfer_busy_i is high. The next descriptor is fetched only after xfer_done_i.
- R7: A descriptor whose count is zero, is not a multiple of 512, exceeds the bytes remaining, or has a reserved bit set produces err_o, and no transfer is issued for it.
- R8: When the entry flagged as last completes, done_o pulses if the remaining budget is zero. Otherwise err_o pulses.
- R9: abort_i in any non-idle state drops every request on the next cycle, pulses err_o, and leaves the walker idle and ready to be armed again.
- R10: done_o and err_o are single-cycle pulses and are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Device has prepared a DMA command |
| dir_i | input | 1 | Direction captured on arm (1 = device to memory) |
| cmd_bytes_i | input | BUD_W | Byte budget of the command, captured on arm |
| start_i | input | 1 | Start strobe |
| tbl_base_i | input | 32 | Descriptor table address, captured on start |
| abort_i | input | 1 | Abandon the current command |
| mrd_req_o | output | 1 | Descriptor read request |
| mrd_addr_o | output | 32 | Descriptor read address |
| mrd_busy_i | input | 1 | Memory port refuses the request this cycle |
| mrd_vld_i | input | 1 | Descriptor response valid |
| mrd_data_i | input | 64 | Descriptor response word |
| xfer_req_o | output | 1 | Region transfer request |
| xfer_addr_o | output | 32 | Region address |
| xfer_len_o | output | 16 | Region length in bytes |
| xfer_dir_o | output | 1 | Region direction |
| xfer_busy_i | input | 1 | Chunking engine cannot accept the request |
| xfer_done_i | input | 1 | Region transfer finished |
| done_o | output | 1 | Command completed cleanly (pulse) |
| err_o | output | 1 | Command ended in error (pulse) |

## Verification
A corrupted pointer shows up on the next descriptor fetch as an address that is not 8 above the previous one. A lost budget subtraction makes the final entry end with err_o instead of done_o, or turns a later in-budget descriptor into a rejection. A miscounted timer shifts the rise of xfer_req_o, or the retry after a refusal, by whole cycles. The bench measures these against the cycle of the descriptor response or of the refusal. A stuck state leaves a request high after abort_i, and this is visible one cycle later.

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam int unsigned DESC_BYTES = 8;
  localparam int unsigned CNT_W      = 16;

  typedef struct packed {
    logic        last;
    logic [14:0] rsvd;
    logic [15:0] cnt;
    logic [31:0] addr;
  } prd_desc_t;

  typedef enum logic [2:0] {
    W_IDLE, W_ARMED, W_FETCH, W_BACKOFF, W_WAIT, W_DELAY, W_XREQ, W_XWAIT
  } walk_st_e;
endpackage

// File: rtl/prd_timer.sv
module prd_timer #(
  parameter int unsigned TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TMR_W-1:0] val_i,
  output logic             zero_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/prd_budget.sv
module prd_budget #(
  parameter int unsigned BUD_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [BUD_W-1:0] load_val_i,
  input  logic             sub_i,
  input  logic [15:0]      sub_val_i,
  output logic [BUD_W-1:0] rem_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_o <= '0;
    else if (load_i) rem_o <= load_val_i;
    else if (sub_i)  rem_o <= rem_o - BUD_W'(sub_val_i);
  end
endmodule

// File: rtl/prd_decode.sv
module prd_decode
  import prd_pkg::*;
#(
  parameter int unsigned SECT_W = 9,
  parameter int unsigned BUD_W  = 24
) (
  input  logic [63:0]      word_i,
  input  logic [BUD_W-1:0] rem_i,
  output logic [31:0]      addr_o,
  output logic [15:0]      cnt_o,
  output logic             last_o,
  output logic [15:0]      secs_o,
  output logic             bad_o
);
  prd_desc_t d;
  logic      misaligned, over;

  assign d          = prd_desc_t'(word_i);
  assign addr_o     = d.addr;
  assign cnt_o      = d.cnt;
  assign last_o     = d.last;
  assign secs_o     = d.cnt >> SECT_W;
  assign misaligned = (d.cnt & 16'((1 << SECT_W) - 1)) != 16'd0;
  assign over       = BUD_W'(d.cnt) > rem_i;
  assign bad_o      = (d.cnt == 16'd0) || misaligned || over || (d.rsvd != '0);
endmodule

// File: rtl/prd_walker.sv
module prd_walker
  import prd_pkg::*;
#(
  parameter int unsigned SECT_W      = 9,
  parameter int unsigned DISK_DLY    = 4,
  parameter int unsigned BACKOFF_CYC = 6,
  parameter int unsigned BUD_W       = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             dir_i,
  input  logic [BUD_W-1:0] cmd_bytes_i,
  input  logic             start_i,
  input  logic [31:0]      tbl_base_i,
  input  logic             abort_i,
  output logic             mrd_req_o,
  output logic [31:0]      mrd_addr_o,
  input  logic             mrd_busy_i,
  input  logic             mrd_vld_i,
  input  logic [63:0]      mrd_data_i,
  output logic             xfer_req_o,
  output logic [31:0]      xfer_addr_o,
  output logic [15:0]      xfer_len_o,
  output logic             xfer_dir_o,
  input  logic             xfer_busy_i,
  input  logic             xfer_done_i,
  output logic             done_o,
  output logic             err_o
);
  localparam int unsigned MAX_SECS = 1 << (CNT_W - SECT_W);
  localparam int unsigned TMR_W    = $clog2(DISK_DLY + MAX_SECS + BACKOFF_CYC + 2);

  walk_st_e         st;
  logic [31:0]      ptr_q, d_addr_q;
  logic [15:0]      d_cnt_q;
  logic             d_last_q, dir_q;
  logic             active, bad_start;
  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic [BUD_W-1:0] rem, rem_after;
  logic             bud_load, bud_sub;
  logic [31:0]      dec_addr;
  logic [15:0]      dec_cnt, dec_secs;
  logic             dec_last, dec_bad;

  assign active    = (st != W_IDLE);
  assign bad_start = start_i && (st != W_ARMED);

  prd_decode #(.SECT_W(SECT_W), .BUD_W(BUD_W)) i_decode (
    .word_i (mrd_data_i),
    .rem_i  (rem),
    .addr_o (dec_addr),
    .cnt_o  (dec_cnt),
    .last_o (dec_last),
    .secs_o (dec_secs),
    .bad_o  (dec_bad)
  );

  // one counter serves both the retry backoff and the media latency
  assign tmr_load = (st == W_FETCH && mrd_busy_i) ||
                    (st == W_WAIT && mrd_vld_i && !dec_bad);
  assign tmr_val  = (st == W_FETCH) ? TMR_W'(BACKOFF_CYC - 1)
                                    : TMR_W'(DISK_DLY) + TMR_W'(dec_secs) - 1'b1;

  prd_timer #(.TMR_W(TMR_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  assign bud_load  = (st == W_IDLE) && arm_i && !start_i;
  assign bud_sub   = (st == W_XWAIT) && xfer_done_i && !abort_i && !start_i;
  assign rem_after = rem - BUD_W'(d_cnt_q);

  prd_budget #(.BUD_W(BUD_W)) i_budget (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (bud_load),
    .load_val_i (cmd_bytes_i),
    .sub_i      (bud_sub),
    .sub_val_i  (d_cnt_q),
    .rem_o      (rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= W_IDLE;
      ptr_q    <= '0;
      d_addr_q <= '0;
      d_cnt_q  <= '0;
      d_last_q <= 1'b0;
      dir_q    <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (abort_i && active) begin
        st    <= W_IDLE;
        err_o <= 1'b1;
      end else if (bad_start) begin
        st    <= W_IDLE;
        err_o <= 1'b1;
      end else begin
        unique case (st)
          W_IDLE: if (arm_i) begin
            st    <= W_ARMED;
            dir_q <= dir_i;
          end
          W_ARMED: if (start_i) begin
            st    <= W_FETCH;
            ptr_q <= tbl_base_i & ~32'h7;
          end
          W_FETCH:   st <= mrd_busy_i ? W_BACKOFF : W_WAIT;
          W_BACKOFF: if (tmr_zero) st <= W_FETCH;
          W_WAIT: if (mrd_vld_i) begin
            ptr_q <= ptr_q + 32'(DESC_BYTES);
            if (dec_bad) begin
              st    <= W_IDLE;
              err_o <= 1'b1;
            end else begin
              st       <= W_DELAY;
              d_addr_q <= dec_addr;
              d_cnt_q  <= dec_cnt;
              d_last_q <= dec_last;
            end
          end
          W_DELAY: if (tmr_zero) st <= W_XREQ;
          W_XREQ:  if (!xfer_busy_i) st <= W_XWAIT;
          W_XWAIT: if (xfer_done_i) begin
            if (d_last_q) begin
              st <= W_IDLE;
              if (rem_after == '0) done_o <= 1'b1;
              else                 err_o  <= 1'b1;
            end else begin
              st <= W_FETCH;
            end
          end
          default: st <= W_IDLE;
        endcase
      end
    end
  end

  assign mrd_req_o   = (st == W_FETCH);
  assign mrd_addr_o  = ptr_q;
  assign xfer_req_o  = (st == W_XREQ);
  assign xfer_addr_o = d_addr_q;
  assign xfer_len_o  = d_cnt_q;
  assign xfer_dir_o  = dir_q;
endmodule

// File: rtl/prd_walker_chk.sv
module prd_walker_chk #(
  parameter int unsigned SECT_W = 9
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        active_i,
  input logic        abort_i,
  input logic        start_i,
  input logic        mrd_req_o,
  input logic        mrd_busy_i,
  input logic [31:0] mrd_addr_o,
  input logic        xfer_req_o,
  input logic        xfer_busy_i,
  input logic [31:0] xfer_addr_o,
  input logic [15:0] xfer_len_o,
  input logic        done_o,
  input logic        err_o
);
  // R10
  done_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R4
  backoff_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrd_req_o && mrd_busy_i |=> !mrd_req_o);
  // R3
  fetch_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrd_req_o |-> mrd_addr_o[2:0] == 3'b000);
  // R6
  xreq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o && xfer_busy_i && !abort_i && !start_i |=>
      xfer_req_o && $stable(xfer_addr_o) && $stable(xfer_len_o));
  // R7
  xlen_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |-> xfer_len_o != 16'd0 &&
      (xfer_len_o & 16'((1 << SECT_W) - 1)) == 16'd0);
  // R9
  abort_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i && active_i |=> !mrd_req_o && !xfer_req_o && err_o && !done_o);
  // R6
  no_dual_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mrd_req_o && xfer_req_o));
endmodule

bind prd_walker prd_walker_chk #(.SECT_W(SECT_W)) i_prd_walker_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .active_i    (active),
  .abort_i     (abort_i),
  .start_i     (start_i),
  .mrd_req_o   (mrd_req_o),
  .mrd_busy_i  (mrd_busy_i),
  .mrd_addr_o  (mrd_addr_o),
  .xfer_req_o  (xfer_req_o),
  .xfer_busy_i (xfer_busy_i),
  .xfer_addr_o (xfer_addr_o),
  .xfer_len_o  (xfer_len_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/test_prd_walker.sv
module test_prd_walker;
  localparam int SECT_W = 9, DISK_DLY = 4, BACKOFF_CYC = 6, BUD_W = 24;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic arm = 0, dir = 0, start = 0, abort = 0;
  logic [BUD_W-1:0] cmd_bytes = '0;
  logic [31:0] tbl_base = '0;
  logic mrd_req_o, mrd_busy = 0, mrd_vld = 0;
  logic [31:0] mrd_addr_o;
  logic [63:0] mrd_data = '0;
  logic xfer_req_o, xfer_dir_o, xfer_busy = 0, xfer_done = 0;
  logic [31:0] xfer_addr_o;
  logic [15:0] xfer_len_o;
  logic done_o, err_o;

  always #10 clk = ~clk;

  prd_walker #(.SECT_W(SECT_W), .DISK_DLY(DISK_DLY), .BACKOFF_CYC(BACKOFF_CYC),
               .BUD_W(BUD_W)) i_prd_walker (
    .clk_i(clk), .rst_ni(rst_ni), .arm_i(arm), .dir_i(dir), .cmd_bytes_i(cmd_bytes),
    .start_i(start), .tbl_base_i(tbl_base), .abort_i(abort),
    .mrd_req_o(mrd_req_o), .mrd_addr_o(mrd_addr_o), .mrd_busy_i(mrd_busy),
    .mrd_vld_i(mrd_vld), .mrd_data_i(mrd_data),
    .xfer_req_o(xfer_req_o), .xfer_addr_o(xfer_addr_o), .xfer_len_o(xfer_len_o),
    .xfer_dir_o(xfer_dir_o), .xfer_busy_i(xfer_busy), .xfer_done_i(xfer_done),
    .done_o(done_o), .err_o(err_o));

  int n_chk = 0, n_bad = 0;
  int cyc = 0, t_vld = 0, lat = 0, done_n = 0, err_n = 0, both_n = 0;
  int fetch_n = 0, xacc_n = 0, xcnt = 0;
  logic xreq_prev = 0;
  logic [63:0] mem [0:15];
  logic [31:0] fa [0:63];
  logic [31:0] xa [0:63];
  logic [15:0] xl [0:63];
  logic        xd [0:63];

  // descriptor memory: one-cycle response to an accepted request
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mrd_vld <= 1'b0;
    if (mrd_req_o && !mrd_busy) begin
      mrd_vld <= 1'b1;
      mrd_data <= mem[mrd_addr_o[6:3]];
      fa[fetch_n & 63] <= mrd_addr_o;
      fetch_n <= fetch_n + 1;
    end
  end

  // chunking engine: done three cycles after accept
  always @(posedge clk) begin
    xfer_done <= 1'b0;
    if (xcnt != 0) begin
      xcnt <= xcnt - 1;
      if (xcnt == 1) xfer_done <= 1'b1;
    end
    if (xfer_req_o && !xfer_busy) begin
      xa[xacc_n & 63] <= xfer_addr_o;
      xl[xacc_n & 63] <= xfer_len_o;
      xd[xacc_n & 63] <= xfer_dir_o;
      xacc_n <= xacc_n + 1;
      xcnt <= 3;
    end
  end

  always @(negedge clk) begin
    if (done_o) done_n = done_n + 1;
    if (err_o) err_n = err_n + 1;
    if (done_o && err_o) both_n = both_n + 1;
    if (mrd_vld) t_vld = cyc;
    if (xfer_req_o && !xreq_prev) lat = cyc - t_vld;
    xreq_prev = xfer_req_o;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [31:0] a, input logic [15:0] c, input bit last);
    return {last, 15'd0, c, a};
  endfunction

  task automatic arm_start(input logic [BUD_W-1:0] b, input bit d, input logic [31:0] base);
    @(negedge clk); arm = 1; dir = d; cmd_bytes = b;
    @(negedge clk); arm = 0; start = 1; tbl_base = base;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_end();
    int d0 = done_n, e0 = err_n;
    for (int i = 0; i < 2000; i++) begin
      if (done_n != d0 || err_n != e0) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!mrd_req_o && !xfer_req_o, "R1 requests", {mrd_req_o, xfer_req_o}, 0);
    chk(!done_o && !err_o, "R1 status", {done_o, err_o}, 0);
  endtask

  task automatic t_single();
    int d0 = done_n, e0 = err_n, x0 = xacc_n, f0 = fetch_n;
    mem[0] = mk(32'h1000, 16'd1024, 1);
    arm_start(1024, 0, 32'h0);
    wait_end();
    chk(done_n == d0 + 1 && err_n == e0, "R8 single done", done_n - d0, 1);
    chk(fa[f0 & 63] == 32'h0, "R3 first fetch", fa[f0 & 63], 0);
    chk(xacc_n == x0 + 1 && xa[x0 & 63] == 32'h1000 && xl[x0 & 63] == 16'd1024 && xd[x0 & 63] == 1'b0,
        "R6 xfer fields", xa[x0 & 63], 32'h1000);
    // vld taken at edge after observation, req visible one negedge after the L-th edge
    chk(lat == DISK_DLY + 2 + 1, "R5 latency 2 sectors", lat, DISK_DLY + 3);
  endtask

  task automatic t_multi();
    int d0 = done_n, x0 = xacc_n, f0 = fetch_n;
    mem[4] = mk(32'h2000, 16'd512, 0);
    mem[5] = mk(32'h3000, 16'd1536, 0);
    mem[6] = mk(32'h4000, 16'd512, 1);
    arm_start(2560, 1, 32'h23);
    wait_end();
    chk(fetch_n == f0 + 3 && fa[f0 & 63] == 32'h20 && fa[(f0 + 1) & 63] == 32'h28 &&
        fa[(f0 + 2) & 63] == 32'h30, "R3 pointer step", fa[(f0 + 2) & 63], 32'h30);
    chk(xacc_n == x0 + 3 && xl[(x0 + 1) & 63] == 16'd1536 && xa[(x0 + 2) & 63] == 32'h4000 &&
        xd[(x0 + 1) & 63] == 1'b1, "R6 multi sequence", xacc_n - x0, 3);
    chk(done_n == d0 + 1, "R8 multi done", done_n - d0, 1);
    chk(lat == DISK_DLY + 1 + 1, "R5 latency 1 sector", lat, DISK_DLY + 2);
  endtask

  task automatic t_backoff();
    int gap = 0, d0 = done_n, x0;
    mem[0] = mk(32'h5000, 16'd512, 1);
    mrd_busy = 1; xfer_busy = 1;
    arm_start(512, 0, 32'h0);
    for (int i = 0; i < 50 && !mrd_req_o; i++) @(negedge clk);
    @(negedge clk);
    while (!mrd_req_o && gap < 100) begin
      gap++;
      if (gap == 1) mrd_busy = 0;
      @(negedge clk);
    end
    chk(gap == BACKOFF_CYC, "R4 backoff gap", gap, BACKOFF_CYC);
    for (int i = 0; i < 50 && !xfer_req_o; i++) @(negedge clk);
    x0 = xacc_n;
    repeat (5) @(negedge clk);
    chk(xfer_req_o && xacc_n == x0, "R6 held while busy", xfer_req_o, 1);
    xfer_busy = 0;
    wait_end();
    chk(done_n == d0 + 1, "R6 done after release", done_n - d0, 1);
  endtask

  task automatic t_reject(input logic [63:0] w, input logic [BUD_W-1:0] b, input string tag);
    int e0 = err_n, d0 = done_n, x0 = xacc_n;
    mem[0] = w;
    arm_start(b, 0, 32'h0);
    wait_end();
    chk(err_n == e0 + 1 && done_n == d0 && xacc_n == x0, tag, err_n - e0, 1);
  endtask

  task automatic t_leftover();
    int e0 = err_n, d0 = done_n, x0 = xacc_n;
    mem[0] = mk(32'h6000, 16'd512, 1);
    arm_start(1024, 0, 32'h0);
    wait_end();
    chk(err_n == e0 + 1 && done_n == d0 && xacc_n == x0 + 1, "R8 leftover budget", err_n - e0, 1);
  endtask

  task automatic t_bad_start();
    int e0 = err_n, f0 = fetch_n, x0 = xacc_n;
    @(negedge clk); start = 1; tbl_base = 0;
    @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    chk(err_n == e0 + 1 && fetch_n == f0, "R2 start unarmed", err_n - e0, 1);
    mem[0] = mk(32'h7000, 16'd512, 1);
    e0 = err_n;
    arm_start(512, 0, 32'h0);
    for (int i = 0; i < 50 && !mrd_vld; i++) @(negedge clk);
    start = 1;
    @(negedge clk); start = 0;
    repeat (40) @(negedge clk);
    chk(err_n == e0 + 1 && xacc_n == x0 && !mrd_req_o, "R2 start mid walk", err_n - e0, 1);
  endtask

  task automatic t_abort();
    int e0 = err_n, x0 = xacc_n, d0;
    mem[0] = mk(32'h8000, 16'd2048, 1);
    arm_start(2048, 1, 32'h0);
    for (int i = 0; i < 50 && !mrd_vld; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    abort = 1;
    @(negedge clk); abort = 0;
    chk(err_o && !mrd_req_o && !xfer_req_o, "R9 abort response", err_o, 1);
    chk(!done_o, "R10 no done with err", done_o, 0);
    repeat (40) @(negedge clk);
    chk(xacc_n == x0 && err_n == e0 + 1, "R9 no transfer after abort", xacc_n - x0, 0);
    d0 = done_n;
    mem[0] = mk(32'h9000, 16'd512, 1);
    arm_start(512, 0, 32'h0);
    wait_end();
    chk(done_n == d0 + 1, "R9 rearm after abort", done_n - d0, 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    repeat (2) @(negedge clk);
    t_single();
    t_multi();
    t_backoff();
    t_reject(mk(32'hA000, 16'd1024, 1), 512, "R7 over budget");
    t_reject(mk(32'hA000, 16'd700, 1), 1024, "R7 not sector multiple");
    t_reject(mk(32'hA000, 16'd0, 1), 1024, "R7 zero count");
    t_reject(mk(32'hA000, 16'd512, 1) | 64'h0001_0000_0000_0000, 512, "R7 reserved bit");
    t_leftover();
    t_bad_start();
    t_abort();
    chk(both_n == 0, "R10 done and err together", both_n, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule